// File: doc/BRIEF.md
# True random bit whitener and word buffer

This block is the digital back end of a hardware random source. A slow, jittery oscillator serves as the sampling clock. On each of its rising edges the block captures the level of a fast free-running oscillator as one raw bit. An XOR compressor reduces every group of raw bits to a single whitened bit, which removes most of the bias in the raw stream. A serial-to-parallel shifter gathers the whitened bits into words. A dual-clock FIFO carries each finished word across to the host, which reads it on its own bus clock.

The generator-side logic runs on a gated copy of the sampling clock. That clock is cut off while the FIFO is full, so no sampling or folding takes place when the words would have nowhere to go. A tamper input wipes the buffer and stops generation. The stop is sticky and is released only by the global reset.

Top module: `trng_backend`

## Requirements
- R1: After reset `rd_empty_o` is 1 and `rd_data_o` is zero.
- R2: Each whitened bit is the XOR of `FOLD_N` (default 8) consecutive raw samples of `fast_osc_i`, taken on rising edges of `slow_clk_i`. The groups do not overlap, and the first sample after reset release starts group 0.
- R3: A word holds `WORD_W` (default 32) whitened bits. The earliest bit lands in the most significant bit and the latest in bit 0.
- R4: The host sees words in the order they were produced. `rd_data_o` shows the oldest word while `rd_empty_o` is 0, and a high `rd_en_i` on a `rd_clk_i` edge removes that word.
- R5: The buffer holds `DEPTH` (default 16) words. While it is full, the generator clock is stopped, so no raw sample is taken and no word is written, overwritten or lost.
- R6: Once the host frees a slot, generation resumes without any other action.
- R7: A high `tamper_i` discards every buffered word and the partial word within a few clock cycles. After that, `rd_empty_o` is 1 and `rd_data_o` is zero.
- R8: The tamper stop is sticky. After `tamper_i` returns low, no new word appears until `rst_ni` is pulsed low. After that reset, generation starts again from a clean state.
- R9: The generator clock enable changes only while `slow_clk_i` is low, so the gated clock carries no glitch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slow_clk_i | input | 1 | Jittery sampling oscillator; generator-side clock |
| fast_osc_i | input | 1 | Fast oscillator level, sampled as raw bit |
| rd_clk_i | input | 1 | Host read clock |
| rst_ni | input | 1 | Global asynchronous reset, active low |
| tamper_i | input | 1 | Tamper alarm from the protective mesh |
| rd_en_i | input | 1 | Pop the oldest word |
| rd_data_o | output | WORD_W | Oldest buffered word, zero when empty |
| rd_empty_o | output | 1 | No word available |

## Verification
The assertions take it for granted that `slow_clk_i` keeps toggling. They also assume that `fast_osc_i` and `tamper_i` never change in the same instant as a rising sampling edge, and that `rd_en_i` is only raised away from a read edge. The bench drives the oscillator level and the tamper alarm on falling edges of the sampling clock, and drives `rd_en_i` on falling edges of the read clock. It releases reset just after a sampling edge, so the first captured bit is known. In every case where data is compared, the host reads before the buffer fills. The one exception is the full-buffer case, where the gated clock freezes the raw-bit index.

// File: rtl/trng_pkg.sv
package trng_pkg;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/trng_sync.sv
module trng_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  import trng_pkg::*;

  logic [W-1:0] stg_q [SYNC_STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(SYNC_STAGES); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(SYNC_STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[SYNC_STAGES-1];
endmodule

// File: rtl/trng_clk_gate.sv
module trng_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic en_q_o,
  output logic gclk_o
);
  // enable captured only in the low phase
  always_latch begin
    if (!clk_i) en_q_o <= en_i;
  end

  assign gclk_o = clk_i & en_q_o;
endmodule

// File: rtl/trng_xor_fold.sv
module trng_xor_fold #(
  parameter int unsigned FOLD_N = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic bit_o,
  output logic bit_vld_o
);
  localparam int unsigned CNT_W = (FOLD_N > 1) ? $clog2(FOLD_N) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FOLD_N - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      acc_q     <= 1'b0;
      bit_o     <= 1'b0;
      bit_vld_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      bit_o     <= acc_q ^ raw_i;
      bit_vld_o <= 1'b1;
      acc_q     <= 1'b0;
      cnt_q     <= '0;
    end else begin
      acc_q     <= acc_q ^ raw_i;
      bit_vld_o <= 1'b0;
      cnt_q     <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/trng_word_pack.sv
module trng_word_pack #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  output logic [WORD_W-1:0] word_o,
  output logic              push_o
);
  localparam int unsigned BC_W = $clog2(WORD_W);
  localparam logic [BC_W-1:0] LAST = BC_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [BC_W-1:0]   bcnt_q;

  // word leaves on the edge that shifts its last bit in
  assign push_o = bit_vld_i && (bcnt_q == LAST);
  assign word_o = {sh_q[WORD_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bcnt_q <= '0;
    end else if (bit_vld_i) begin
      sh_q   <= word_o;
      bcnt_q <= (bcnt_q == LAST) ? '0 : bcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/trng_async_fifo.sv
module trng_async_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic          wclk_i,
  input  logic          wsclk_i,
  input  logic          wrst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  output logic          full_o,
  input  logic          rclk_i,
  input  logic          rrst_ni,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [PW-1:0] rgray_ws, wgray_rs;
  logic [PW-1:0] wbin_nxt, rbin_nxt;
  logic          pop_ok;

  // write side, gated clock
  assign wbin_nxt = wbin_q + PW'(push_i);

  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= to_gray(wbin_nxt);
    end
  end

  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[wbin_q[AW-1:0]] <= wdata_i;
    end
  end

  // read pointer must cross even while the write clock is gated
  trng_sync #(.W(PW)) u_rptr_sync (
    .clk_i  (wsclk_i),
    .rst_ni (wrst_ni),
    .d_i    (rgray_q),
    .q_o    (rgray_ws)
  );

  assign full_o = (wgray_q == {~rgray_ws[PW-1:PW-2], rgray_ws[PW-3:0]});

  // read side
  trng_sync #(.W(PW)) u_wptr_sync (
    .clk_i  (rclk_i),
    .rst_ni (rrst_ni),
    .d_i    (wgray_q),
    .q_o    (wgray_rs)
  );

  assign empty_o  = (rgray_q == wgray_rs);
  assign pop_ok   = pop_i && !empty_o;
  assign rbin_nxt = rbin_q + PW'(pop_ok);
  assign rdata_o  = empty_o ? '0 : mem_q[rbin_q[AW-1:0]];

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_q <= to_gray(rbin_nxt);
    end
  end
endmodule

// File: rtl/trng_backend.sv
module trng_backend #(
  parameter int unsigned FOLD_N = 8,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              slow_clk_i,
  input  logic              fast_osc_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic              tamper_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_empty_o
);
  logic tsync_w, tsync_r;
  logic tamp_w, tamp_r;
  logic gen_rst_n, rd_rst_n;
  logic gate_en, gclk;
  logic full_w;
  logic fold_bit, fold_vld;
  logic push_w;
  logic [WORD_W-1:0] word_w;

  // tamper alarm, sticky per domain until global reset
  trng_sync #(.W(1)) u_tsync_w (
    .clk_i  (slow_clk_i),
    .rst_ni (rst_ni),
    .d_i    (tamper_i),
    .q_o    (tsync_w)
  );

  trng_sync #(.W(1)) u_tsync_r (
    .clk_i  (rd_clk_i),
    .rst_ni (rst_ni),
    .d_i    (tamper_i),
    .q_o    (tsync_r)
  );

  always_ff @(posedge slow_clk_i or negedge rst_ni) begin
    if (!rst_ni) tamp_w <= 1'b0;
    else         tamp_w <= tamp_w | tsync_w;
  end

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni) tamp_r <= 1'b0;
    else         tamp_r <= tamp_r | tsync_r;
  end

  // tamper holds both sides in reset: wipes words and partial word
  assign gen_rst_n = rst_ni & ~tamp_w;
  assign rd_rst_n  = rst_ni & ~tamp_r;

  trng_clk_gate u_gate (
    .clk_i  (slow_clk_i),
    .en_i   (~full_w & ~tamp_w),
    .en_q_o (gate_en),
    .gclk_o (gclk)
  );

  trng_xor_fold #(.FOLD_N(FOLD_N)) u_fold (
    .clk_i     (gclk),
    .rst_ni    (gen_rst_n),
    .raw_i     (fast_osc_i),
    .bit_o     (fold_bit),
    .bit_vld_o (fold_vld)
  );

  trng_word_pack #(.WORD_W(WORD_W)) u_pack (
    .clk_i     (gclk),
    .rst_ni    (gen_rst_n),
    .bit_i     (fold_bit),
    .bit_vld_i (fold_vld),
    .word_o    (word_w),
    .push_o    (push_w)
  );

  trng_async_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .wclk_i  (gclk),
    .wsclk_i (slow_clk_i),
    .wrst_ni (gen_rst_n),
    .push_i  (push_w),
    .wdata_i (word_w),
    .full_o  (full_w),
    .rclk_i  (rd_clk_i),
    .rrst_ni (rd_rst_n),
    .pop_i   (rd_en_i),
    .rdata_o (rd_data_o),
    .empty_o (rd_empty_o)
  );
endmodule

// File: rtl/trng_backend_chk.sv
module trng_backend_chk (
  input logic slow_clk_i,
  input logic rd_clk_i,
  input logic rst_ni,
  input logic gate_en,
  input logic full_w,
  input logic push_w,
  input logic tamp_w,
  input logic tamp_r,
  input logic rd_empty_o
);
  logic armed_q;

  always_ff @(posedge slow_clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R5
  no_push_when_full_chk: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    (push_w && gate_en) |-> !full_w);

  // R7
  tamper_empty_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    tamp_r |-> rd_empty_o);

  // R8
  tamper_sticky_chk: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    tamp_w |=> tamp_w);

  // R8
  tamper_halt_chk: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    tamp_w |=> !gate_en);

  // R9
  always @(gate_en) begin
    if (armed_q && rst_ni) begin
      gate_stable_chk: assert (!slow_clk_i) else $error("gate enable moved in high phase");
    end
  end
endmodule

bind trng_backend trng_backend_chk chk_i (
  .slow_clk_i (slow_clk_i),
  .rd_clk_i   (rd_clk_i),
  .rst_ni     (rst_ni),
  .gate_en    (gate_en),
  .full_w     (full_w),
  .push_w     (push_w),
  .tamp_w     (tamp_w),
  .tamp_r     (tamp_r),
  .rd_empty_o (rd_empty_o)
);

// File: tb/trng_backend_tb_top.sv
module trng_backend_tb_top;
  localparam int FOLD  = 8;
  localparam int W     = 32;
  localparam int DEPTH = 16;

  logic slow_clk = 1'b0;
  logic rd_clk   = 1'b0;
  logic rst_ni   = 1'b0;
  logic fast_osc = 1'b0;
  logic tamper   = 1'b0;
  logic rd_en    = 1'b0;
  logic [W-1:0] rd_data;
  logic rd_empty;

  int checks = 0;
  int fails  = 0;
  int mode_r = 0;
  int idx    = 0;

  always #13 slow_clk = ~slow_clk;
  always #5  rd_clk   = ~rd_clk;

  trng_backend dut_i (
    .slow_clk_i (slow_clk),
    .fast_osc_i (fast_osc),
    .rd_clk_i   (rd_clk),
    .rst_ni     (rst_ni),
    .tamper_i   (tamper),
    .rd_en_i    (rd_en),
    .rd_data_o  (rd_data),
    .rd_empty_o (rd_empty)
  );

  function automatic logic raw_bit(input int mode, input int n);
    int pos;
    int j;
    logic g;
    pos = n % FOLD;
    j   = n / FOLD;
    g   = 1'(((j ^ (j >> 1) ^ (j >> 3) ^ (j >> 6)) & 1));
    case (mode)
      0:       return 1'b1;
      1:       return (pos == 0) && (j % 2 == 0);
      default: return (pos == 3) ? g : ((pos == 5) || (pos == 6));
    endcase
  endfunction

  function automatic logic [W-1:0] exp_word(input int mode, input int k);
    logic [W-1:0] w;
    logic b;
    w = '0;
    for (int bi = 0; bi < W; bi++) begin
      b = 1'b0;
      for (int r = 0; r < FOLD; r++) b = b ^ raw_bit(mode, (k * W + bi) * FOLD + r);
      w = {w[W-2:0], b};
    end
    return w;
  endfunction

  // oscillator level changes away from the sampling edge
  always @(negedge slow_clk) begin
    fast_osc <= raw_bit(mode_r, idx);
    idx = idx + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input int mode);
    rst_ni = 1'b0;
    tamper = 1'b0;
    rd_en  = 1'b0;
    mode_r = mode;
    repeat (4) @(posedge slow_clk);
    @(posedge slow_clk);
    #2;
    idx    = 0;
    rst_ni = 1'b1;
  endtask

  task automatic read_word(output logic [W-1:0] d, output bit ok);
    ok = 1'b0;
    d  = '0;
    for (int t = 0; t < 20000; t++) begin
      @(negedge rd_clk);
      if (!rd_empty) begin
        ok = 1'b1;
        break;
      end
    end
    if (ok) begin
      d     = rd_data;
      rd_en = 1'b1;
      @(negedge rd_clk);
      rd_en = 1'b0;
    end
  endtask

  task automatic t_reset();
    do_reset(0);
    @(negedge rd_clk);
    check(rd_empty == 1'b1, "R1", "empty after reset", W'(rd_empty), W'(1));
    check(rd_data == '0, "R1", "data after reset", rd_data, '0);
  endtask

  task automatic t_fold_ones();
    logic [W-1:0] d;
    bit ok;
    do_reset(0);
    read_word(d, ok);
    check(ok, "R2", "word available", W'(ok), W'(1));
    check(d == '0, "R2", "even ones fold to zero", d, '0);
  endtask

  task automatic t_bit_order();
    logic [W-1:0] d;
    bit ok;
    do_reset(1);
    read_word(d, ok);
    check(ok && d == 32'hAAAA_AAAA, "R3", "first bit in MSB", d, 32'hAAAA_AAAA);
  endtask

  task automatic t_stream();
    logic [W-1:0] d;
    bit ok;
    do_reset(2);
    for (int k = 0; k < 3; k++) begin
      read_word(d, ok);
      check(ok && d == exp_word(2, k), "R4", $sformatf("stream word %0d", k), d, exp_word(2, k));
    end
  endtask

  task automatic t_full();
    logic [W-1:0] d;
    bit ok;
    do_reset(2);
    repeat (DEPTH * W * FOLD + 300) @(posedge slow_clk);
    @(negedge rd_clk);
    check(!rd_empty, "R5", "full buffer not empty", W'(rd_empty), W'(0));
    for (int k = 0; k < DEPTH; k++) begin
      read_word(d, ok);
      check(ok && d == exp_word(2, k), "R5", $sformatf("held word %0d", k), d, exp_word(2, k));
    end
    check(rd_empty == 1'b1, "R5", "nothing beyond capacity", W'(rd_empty), W'(1));
    repeat (W * FOLD + 100) @(posedge slow_clk);
    @(negedge rd_clk);
    check(!rd_empty, "R6", "generation resumed", W'(rd_empty), W'(0));
  endtask

  task automatic t_tamper();
    logic [W-1:0] d;
    bit ok;
    do_reset(1);
    repeat (2 * W * FOLD + 100) @(posedge slow_clk);
    @(negedge rd_clk);
    check(!rd_empty, "R7", "words before tamper", W'(rd_empty), W'(0));
    @(negedge slow_clk);
    tamper = 1'b1;
    repeat (10) @(negedge rd_clk);
    check(rd_empty == 1'b1, "R7", "empty after tamper", W'(rd_empty), W'(1));
    check(rd_data == '0, "R7", "zero data after tamper", rd_data, '0);
    @(negedge slow_clk);
    tamper = 1'b0;
    repeat (3 * W * FOLD) @(posedge slow_clk);
    @(negedge rd_clk);
    check(rd_empty == 1'b1, "R8", "still halted", W'(rd_empty), W'(1));
    check(rd_data == '0, "R8", "still zero data", rd_data, '0);
    do_reset(1);
    read_word(d, ok);
    check(ok && d == 32'hAAAA_AAAA, "R8", "clean restart after reset", d, 32'hAAAA_AAAA);
  endtask

  initial begin
    repeat (180000) @(posedge rd_clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_fold_ones();
    t_bit_order();
    t_stream();
    t_full();
    t_tamper();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule